// File: doc/BRIEF.md
# Dependence-Aware Cluster Steering Unit

This unit sits at the dispatch stage of a clustered out-of-order core. It picks the execution cluster for one renamed instruction per cycle. It looks at the instruction's class, the number of source operands it reads, whether each source value is already visible in every cluster, and the current fill level of every cluster's issue queue. It also keeps a small table, indexed by physical register, that records which cluster produced each register and a sequence stamp for that producer. Dependence-aware policies use the table to follow producers. The readiness policy also uses the stamp to find the youngest source.

A three-bit policy selector chooses among six behaviours. Three are rotational: fixed-size groups, cut after a branch, and cut at a load. One balances load. Two follow dependences: by producer, or by readiness. The rotational policies share a pointer, a group counter and a two-state cut machine (`CUT_HOLD`, `CUT_ADVANCE`). The machine moves from `CUT_HOLD` to `CUT_ADVANCE` when a branch is steered in branch-cut policy. It moves from `CUT_ADVANCE` back to `CUT_HOLD` when a non-branch is steered in that policy. Reset and flush force it to `CUT_HOLD`. The decision is combinational, so the chosen cluster appears in the same cycle as the request. The table, the stamp counter and the rotation state update on the following clock edge.

Top module: `steer_unit`

## Requirements
- R1: Policy 0 (groups). Each group of MOD_N consecutive steered instructions goes to one cluster. The next group goes to the next cluster index, and index NCLUST-1 wraps to 0.
- R2: Policy 1 (branch cut). Instructions stay on the current cluster. The first instruction steered after a branch (class code 2'b01) goes to the next cluster in wrapping order, and that cluster becomes the current one.
- R3: Policy 2 (load cut). A load (class code 2'b10) goes to the next cluster in wrapping order, and that cluster becomes the current one. Any other instruction stays on the current cluster.
- R4: Policy 3 (and the unused codes 6 and 7) goes to the cluster with the smallest occupancy. Cluster c's occupancy is occ_i[c*OCC_W +: OCC_W]. Ties go to the lowest index.
- R5: Policy 4 (producer). Source count 0 uses the R4 choice. Count 1 goes to source 0's producer. Count 2 or 3 reads both sources: if both producers agree, that cluster is used; otherwise the one with the smaller occupancy is used, with ties to the lower index.
- R6: Policy 5 (readiness). Only the sources that are counted are examined. If each of them has its global-ready flag set (which includes having no source), the instruction goes to the R4 choice. Otherwise it goes to the producer of the youngest counted source.
- R7: The youngest source is source 1 only if (stamp1 - stamp0) mod 2^SEQ_W is nonzero and below 2^(SEQ_W-1). Otherwise it is source 0.
- R8: A steered instruction with dst_valid_i records its cluster and the current stamp against dst_preg_i. The stamp counter starts at 0 and advances once per steered instruction. A register not written since reset reads as cluster 0, stamp 0.
- R9: When flush_i is high, the request in that cycle is dropped: no table write and no stamp advance. The rotation pointer, the group count and the cut state return to cluster 0 / CUT_HOLD, exactly as after reset.
- R10: steer_valid_o is high in exactly the cycles where valid_i is high and flush_i is low. cluster_o is valid in those same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Pipeline flush; drops the current request |
| valid_i | input | 1 | A renamed instruction is presented |
| mode_i | input | 3 | Policy selector (0 groups, 1 branch cut, 2 load cut, 3 least loaded, 4 producer, 5 readiness) |
| iclass_i | input | 2 | Class: 01 branch, 10 load, other values plain |
| nsrc_i | input | 2 | Number of source operands (3 treated as 2) |
| src0_preg_i | input | 6 | Physical register of source 0 |
| src1_preg_i | input | 6 | Physical register of source 1 |
| src0_gready_i | input | 1 | Source 0 value visible in every cluster |
| src1_gready_i | input | 1 | Source 1 value visible in every cluster |
| occ_i | input | 16 | Packed per-cluster issue-queue occupancy, OCC_W bits each |
| dst_valid_i | input | 1 | Instruction writes a destination register |
| dst_preg_i | input | 6 | Destination physical register |
| steer_valid_o | output | 1 | A cluster decision is issued this cycle |
| cluster_o | output | 2 | Chosen cluster index |

## Verification
Two events can meet in one cycle: a flush and a valid instruction that names a destination register. In that cycle the flush must win over both the table write and the rotation update. The bench raises flush at random, and often together with valid_i and dst_valid_i. Later producer-mode requests read the flushed register, and rotational requests check that rotation restarts at cluster 0. Together these show whether the dropped instruction left any trace.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [2:0] {
        MODE_GROUP = 3'd0,
        MODE_BRCUT = 3'd1,
        MODE_LDCUT = 3'd2,
        MODE_LEAST = 3'd3,
        MODE_PROD  = 3'd4,
        MODE_READY = 3'd5
    } steer_mode_e;

    typedef enum logic [1:0] {
        CLS_PLAIN  = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_LOAD   = 2'b10,
        CLS_RSVD   = 2'b11
    } inst_class_e;

    typedef enum logic {
        CUT_HOLD    = 1'b0,
        CUT_ADVANCE = 1'b1
    } cut_state_e;

endpackage

// File: rtl/steer_least_pick.sv
module steer_least_pick #(
    parameter int NCLUST = 4,
    parameter int OCC_W  = 4,
    localparam int CL_W  = $clog2(NCLUST)
) (
    input  logic [NCLUST*OCC_W-1:0] occ_i,
    output logic [CL_W-1:0]         pick_o
);

    logic [OCC_W-1:0] best_occ [NCLUST];
    logic [CL_W-1:0]  best_idx [NCLUST];

    assign best_occ[0] = occ_i[OCC_W-1:0];
    assign best_idx[0] = '0;

    // Linear chain; a later cluster replaces the leader only when strictly smaller.
    for (genvar g = 1; g < NCLUST; g++) begin : g_chain
        logic [OCC_W-1:0] cur;
        assign cur         = occ_i[g*OCC_W +: OCC_W];
        assign best_occ[g] = (cur < best_occ[g-1]) ? cur : best_occ[g-1];
        assign best_idx[g] = (cur < best_occ[g-1]) ? CL_W'(g) : best_idx[g-1];
    end

    assign pick_o = best_idx[NCLUST-1];

endmodule

// File: rtl/steer_prod_table.sv
module steer_prod_table #(
    parameter int NPREG = 64,
    parameter int CL_W  = 2,
    parameter int SEQ_W = 8,
    localparam int PR_W = $clog2(NPREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PR_W-1:0]  rd0_addr_i,
    input  logic [PR_W-1:0]  rd1_addr_i,
    output logic [CL_W-1:0]  rd0_cl_o,
    output logic [SEQ_W-1:0] rd0_seq_o,
    output logic [CL_W-1:0]  rd1_cl_o,
    output logic [SEQ_W-1:0] rd1_seq_o,
    input  logic             wr_en_i,
    input  logic [PR_W-1:0]  wr_addr_i,
    input  logic [CL_W-1:0]  wr_cl_i,
    input  logic [SEQ_W-1:0] wr_seq_i
);

    logic [CL_W-1:0]  cl_q  [NPREG];
    logic [SEQ_W-1:0] seq_q [NPREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPREG; i++) begin
                cl_q[i]  <= '0;
                seq_q[i] <= '0;
            end
        end else if (wr_en_i) begin
            cl_q[wr_addr_i]  <= wr_cl_i;
            seq_q[wr_addr_i] <= wr_seq_i;
        end
    end

    assign rd0_cl_o  = cl_q[rd0_addr_i];
    assign rd0_seq_o = seq_q[rd0_addr_i];
    assign rd1_cl_o  = cl_q[rd1_addr_i];
    assign rd1_seq_o = seq_q[rd1_addr_i];

endmodule

// File: rtl/steer_rr_fsm.sv
module steer_rr_fsm
    import steer_pkg::*;
#(
    parameter int NCLUST = 4,
    parameter int MOD_N  = 3,
    localparam int CL_W  = $clog2(NCLUST),
    localparam int CNT_W = $clog2(MOD_N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            fire_i,
    input  logic [2:0]      mode_i,
    input  logic [1:0]      iclass_i,
    output logic [CL_W-1:0] rr_cl_o
);

    cut_state_e      state_q, state_d;
    logic [CL_W-1:0] ptr_q, ptr_d, ptr_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    steer_mode_e     mode;
    logic            is_branch, is_load;

    assign mode      = steer_mode_e'(mode_i);
    assign is_branch = (inst_class_e'(iclass_i) == CLS_BRANCH);
    assign is_load   = (inst_class_e'(iclass_i) == CLS_LOAD);
    assign ptr_nxt   = (ptr_q == CL_W'(NCLUST - 1)) ? '0 : CL_W'(ptr_q + 1'b1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CUT_HOLD;
            ptr_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: cluster chosen by the rotational policies
    always_comb begin
        unique case (mode)
            MODE_BRCUT: rr_cl_o = (state_q == CUT_ADVANCE) ? ptr_nxt : ptr_q;
            MODE_LDCUT: rr_cl_o = is_load ? ptr_nxt : ptr_q;
            default:    rr_cl_o = ptr_q;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        cnt_d   = cnt_q;
        if (flush_i) begin
            state_d = CUT_HOLD;
            ptr_d   = '0;
            cnt_d   = '0;
        end else if (fire_i) begin
            unique case (mode)
                MODE_GROUP: begin
                    if (cnt_q == CNT_W'(MOD_N - 1)) begin
                        cnt_d = '0;
                        ptr_d = ptr_nxt;
                    end else begin
                        cnt_d = CNT_W'(cnt_q + 1'b1);
                    end
                end
                MODE_BRCUT: begin
                    ptr_d = rr_cl_o;
                    unique case (state_q)
                        CUT_HOLD:    state_d = is_branch ? CUT_ADVANCE : CUT_HOLD;
                        CUT_ADVANCE: state_d = is_branch ? CUT_ADVANCE : CUT_HOLD;
                        default:     state_d = CUT_HOLD;
                    endcase
                end
                MODE_LDCUT: ptr_d = rr_cl_o;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/steer_dep_pick.sv
module steer_dep_pick #(
    parameter int NCLUST = 4,
    parameter int OCC_W  = 4,
    parameter int SEQ_W  = 8,
    localparam int CL_W  = $clog2(NCLUST)
) (
    input  logic [NCLUST*OCC_W-1:0] occ_i,
    input  logic                    use0_i,
    input  logic                    use1_i,
    input  logic [CL_W-1:0]         s0_cl_i,
    input  logic [CL_W-1:0]         s1_cl_i,
    input  logic [SEQ_W-1:0]        s0_seq_i,
    input  logic [SEQ_W-1:0]        s1_seq_i,
    input  logic                    g0_i,
    input  logic                    g1_i,
    input  logic [CL_W-1:0]         least_cl_i,
    output logic [CL_W-1:0]         prod_cl_o,
    output logic [CL_W-1:0]         ready_cl_o
);

    logic [OCC_W-1:0] occ0, occ1;
    logic [CL_W-1:0]  pair_cl;
    logic [SEQ_W-1:0] age_gap;
    logic             s1_younger, all_ready;

    assign occ0 = occ_i[s0_cl_i*OCC_W +: OCC_W];
    assign occ1 = occ_i[s1_cl_i*OCC_W +: OCC_W];

    always_comb begin
        if (occ0 < occ1)      pair_cl = s0_cl_i;
        else if (occ1 < occ0) pair_cl = s1_cl_i;
        else                  pair_cl = (s0_cl_i < s1_cl_i) ? s0_cl_i : s1_cl_i;
    end

    always_comb begin
        if (!use0_i)                 prod_cl_o = least_cl_i;
        else if (!use1_i)            prod_cl_o = s0_cl_i;
        else if (s0_cl_i == s1_cl_i) prod_cl_o = s0_cl_i;
        else                         prod_cl_o = pair_cl;
    end

    assign age_gap    = s1_seq_i - s0_seq_i;
    assign s1_younger = use1_i && (age_gap != '0) && !age_gap[SEQ_W-1];
    assign all_ready  = (!use0_i || g0_i) && (!use1_i || g1_i);
    assign ready_cl_o = all_ready ? least_cl_i : (s1_younger ? s1_cl_i : s0_cl_i);

endmodule

// File: rtl/steer_unit.sv
module steer_unit
    import steer_pkg::*;
#(
    parameter int NCLUST = 4,
    parameter int NPREG  = 64,
    parameter int OCC_W  = 4,
    parameter int MOD_N  = 3,
    parameter int SEQ_W  = 8,
    localparam int CL_W  = $clog2(NCLUST),
    localparam int PR_W  = $clog2(NPREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_i,
    input  logic                    valid_i,
    input  logic [2:0]              mode_i,
    input  logic [1:0]              iclass_i,
    input  logic [1:0]              nsrc_i,
    input  logic [PR_W-1:0]         src0_preg_i,
    input  logic [PR_W-1:0]         src1_preg_i,
    input  logic                    src0_gready_i,
    input  logic                    src1_gready_i,
    input  logic [NCLUST*OCC_W-1:0] occ_i,
    input  logic                    dst_valid_i,
    input  logic [PR_W-1:0]         dst_preg_i,
    output logic                    steer_valid_o,
    output logic [CL_W-1:0]         cluster_o
);

    logic             fire, use0, use1;
    logic [SEQ_W-1:0] seq_q;
    logic [CL_W-1:0]  src0_cl, src1_cl, least_cl, prod_cl, ready_cl, rr_cl;
    logic [SEQ_W-1:0] src0_seq, src1_seq;
    steer_mode_e      mode;

    assign fire = valid_i && !flush_i;
    assign use0 = (nsrc_i != 2'd0);
    assign use1 = nsrc_i[1];
    assign mode = steer_mode_e'(mode_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    seq_q <= '0;
        else if (fire) seq_q <= SEQ_W'(seq_q + 1'b1);
    end

    steer_prod_table #(.NPREG(NPREG), .CL_W(CL_W), .SEQ_W(SEQ_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd0_addr_i (src0_preg_i),
        .rd1_addr_i (src1_preg_i),
        .rd0_cl_o   (src0_cl),
        .rd0_seq_o  (src0_seq),
        .rd1_cl_o   (src1_cl),
        .rd1_seq_o  (src1_seq),
        .wr_en_i    (fire && dst_valid_i),
        .wr_addr_i  (dst_preg_i),
        .wr_cl_i    (cluster_o),
        .wr_seq_i   (seq_q)
    );

    steer_least_pick #(.NCLUST(NCLUST), .OCC_W(OCC_W)) u_least (
        .occ_i  (occ_i),
        .pick_o (least_cl)
    );

    steer_dep_pick #(.NCLUST(NCLUST), .OCC_W(OCC_W), .SEQ_W(SEQ_W)) u_dep (
        .occ_i      (occ_i),
        .use0_i     (use0),
        .use1_i     (use1),
        .s0_cl_i    (src0_cl),
        .s1_cl_i    (src1_cl),
        .s0_seq_i   (src0_seq),
        .s1_seq_i   (src1_seq),
        .g0_i       (src0_gready_i),
        .g1_i       (src1_gready_i),
        .least_cl_i (least_cl),
        .prod_cl_o  (prod_cl),
        .ready_cl_o (ready_cl)
    );

    steer_rr_fsm #(.NCLUST(NCLUST), .MOD_N(MOD_N)) u_rr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .fire_i   (fire),
        .mode_i   (mode_i),
        .iclass_i (iclass_i),
        .rr_cl_o  (rr_cl)
    );

    // Output process: policy select
    always_comb begin
        steer_valid_o = fire;
        unique case (mode)
            MODE_GROUP, MODE_BRCUT, MODE_LDCUT: cluster_o = rr_cl;
            MODE_PROD:                          cluster_o = prod_cl;
            MODE_READY:                         cluster_o = ready_cl;
            default:                            cluster_o = least_cl;
        endcase
    end

endmodule

// File: rtl/steer_unit_chk.sv
module steer_unit_chk #(
    parameter int NCLUST = 4,
    parameter int OCC_W  = 4,
    localparam int CL_W  = $clog2(NCLUST)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush_i,
    input logic [2:0]              mode_i,
    input logic [1:0]              iclass_i,
    input logic [1:0]              nsrc_i,
    input logic [NCLUST*OCC_W-1:0] occ_i,
    input logic                    steer_valid_o,
    input logic [CL_W-1:0]         cluster_o,
    input logic [CL_W-1:0]         src0_cl
);

    function automatic logic [CL_W-1:0] wrap_inc(input logic [CL_W-1:0] c);
        return (c == CL_W'(NCLUST - 1)) ? '0 : CL_W'(c + 1'b1);
    endfunction

    logic [OCC_W-1:0] chosen_occ;
    assign chosen_occ = occ_i[cluster_o*OCC_W +: OCC_W];

    // R1
    group_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_valid_o && mode_i == 3'd0 && $past(steer_valid_o && mode_i == 3'd0))
        |-> (cluster_o == $past(cluster_o) || cluster_o == wrap_inc($past(cluster_o))));

    // R2
    branch_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_valid_o && mode_i == 3'd1 &&
         $past(steer_valid_o && mode_i == 3'd1 && iclass_i == 2'b01))
        |-> cluster_o == wrap_inc($past(cluster_o)));

    // R4
    for (genvar c = 0; c < NCLUST; c++) begin : g_ll
        least_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (steer_valid_o && mode_i == 3'd3) |-> chosen_occ <= occ_i[c*OCC_W +: OCC_W]);
    end

    // R5
    prod_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_valid_o && mode_i == 3'd4 && nsrc_i == 2'd1) |-> cluster_o == src0_cl);

    // R9
    flush_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_i) && steer_valid_o && mode_i == 3'd0) |-> cluster_o == '0);

endmodule

bind steer_unit steer_unit_chk #(.NCLUST(NCLUST), .OCC_W(OCC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .mode_i        (mode_i),
    .iclass_i      (iclass_i),
    .nsrc_i        (nsrc_i),
    .occ_i         (occ_i),
    .steer_valid_o (steer_valid_o),
    .cluster_o     (cluster_o),
    .src0_cl       (src0_cl)
);

// File: tb/steer_unit_bench.sv
module steer_unit_bench;

    localparam int NCL = 4;
    localparam int OW  = 4;
    localparam int NP  = 64;
    localparam int MN  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0, valid_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [1:0]  iclass_i = '0, nsrc_i = '0;
    logic [5:0]  src0_preg_i = '0, src1_preg_i = '0, dst_preg_i = '0;
    logic        src0_gready_i = 1'b0, src1_gready_i = 1'b0, dst_valid_i = 1'b0;
    logic [15:0] occ_i = '0;
    logic        steer_valid_o;
    logic [1:0]  cluster_o;

    always #5 clk = ~clk;

    steer_unit u_steer_unit (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .valid_i(valid_i),
        .mode_i(mode_i), .iclass_i(iclass_i), .nsrc_i(nsrc_i),
        .src0_preg_i(src0_preg_i), .src1_preg_i(src1_preg_i),
        .src0_gready_i(src0_gready_i), .src1_gready_i(src1_gready_i),
        .occ_i(occ_i), .dst_valid_i(dst_valid_i), .dst_preg_i(dst_preg_i),
        .steer_valid_o(steer_valid_o), .cluster_o(cluster_o)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Reference state derived from the requirements
    int m_cl [NP];
    int m_seq[NP];
    int m_ptr = 0, m_cnt = 0, m_adv = 0, m_stamp = 0;
    int unsigned rs = 32'h1234_5679;

    function automatic int unsigned rnd();
        rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
        return rs;
    endfunction

    function automatic int occ_of(logic [15:0] o, int c);
        return int'(o[c*OW +: OW]);
    endfunction

    function automatic int least(logic [15:0] o);
        int b = 0;
        for (int c = 1; c < NCL; c++) if (occ_of(o, c) < occ_of(o, b)) b = c;
        return b;
    endfunction

    function automatic int inc(int c);
        return (c + 1) % NCL;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int md, bit v, bit fl, int ns, int s0, int s1, bit g0, bit g1,
                        int cls, logic [15:0] occ, bit dv, int dst, bit after_fl);
        int exp, c0, c1, gap;
        bit u0, u1, y1;
        string tag;
        @(negedge clk);
        mode_i = 3'(md); valid_i = v; flush_i = fl; nsrc_i = 2'(ns);
        src0_preg_i = 6'(s0); src1_preg_i = 6'(s1); src0_gready_i = g0; src1_gready_i = g1;
        iclass_i = 2'(cls); occ_i = occ; dst_valid_i = dv; dst_preg_i = 6'(dst);
        #1;
        u0 = (ns != 0); u1 = (ns >= 2);
        c0 = m_cl[s0]; c1 = m_cl[s1];
        gap = (m_seq[s1] - m_seq[s0]) & 255;
        y1 = u1 && gap != 0 && gap < 128;           // R7
        case (md)
            0: begin exp = m_ptr; tag = "R1"; end
            1: begin exp = m_adv ? inc(m_ptr) : m_ptr; tag = "R2"; end
            2: begin exp = (cls == 2) ? inc(m_ptr) : m_ptr; tag = "R3"; end
            4: begin
                tag = "R5/R8";
                if (!u0) exp = least(occ);
                else if (!u1 || c0 == c1) exp = c0;
                else if (occ_of(occ, c0) < occ_of(occ, c1)) exp = c0;
                else if (occ_of(occ, c1) < occ_of(occ, c0)) exp = c1;
                else exp = (c0 < c1) ? c0 : c1;
            end
            5: begin
                tag = "R6/R7";
                if ((!u0 || g0) && (!u1 || g1)) exp = least(occ);
                else exp = y1 ? c1 : c0;
            end
            default: begin exp = least(occ); tag = "R4"; end
        endcase
        if (after_fl) tag = {tag, "+R9"};
        check(fl ? "R9/R10 valid" : "R10 valid", int'(steer_valid_o), int'(v && !fl));
        if (v && !fl) check(tag, int'(cluster_o), exp);
        @(posedge clk);
        if (fl) begin
            m_ptr = 0; m_cnt = 0; m_adv = 0;
        end else if (v) begin
            case (md)
                0: if (m_cnt == MN - 1) begin m_cnt = 0; m_ptr = inc(m_ptr); end
                   else m_cnt++;
                1: begin m_ptr = exp; m_adv = (cls == 1); end
                2: m_ptr = exp;
                default: ;
            endcase
            if (dv) begin m_cl[dst] = exp; m_seq[dst] = m_stamp; end
            m_stamp = (m_stamp + 1) & 255;
        end
    endtask

    initial begin : watchdog
        #(10 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < NP; i++) begin m_cl[i] = 0; m_seq[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", int'(steer_valid_o), 0);
        rst_n = 1'b1;
        // Reset state: groups start at cluster 0; unwritten register reads cluster 0 (R8)
        step(4, 1, 0, 1, 40, 0, 0, 0, 0, 16'h0123, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 0, 0, 0);
        // Directed R1 sequence then flush collision with a destination write (R9)
        for (int k = 0; k < 7; k++)
            step(0, 1, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 1, 20 + k, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0, 0, 16'h0000, 1, 20, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 0, 0, 1);
        step(4, 1, 0, 1, 20, 0, 0, 0, 0, 16'h0000, 0, 0, 0);
        // Near-exhaustive random sweeps over every policy code
        for (int md = 0; md < 8; md++) begin
            step(md, 0, 1, 0, 0, 0, 0, 0, 0, 16'h0000, 0, 0, 0);
            for (int k = 0; k < 600; k++) begin
                int unsigned r1, r2, r3;
                bit fl, prev_fl;
                r1 = rnd(); r2 = rnd(); r3 = rnd();
                prev_fl = (k == 0);
                fl = (r1[4:0] == 5'd0);
                step(md, r1[7:5] != 3'd0, fl, int'(r1[9:8]),
                     int'(r1[13:10]), int'(r1[17:14]), r1[18], r1[19],
                     int'(r1[21:20]), r2[15:0], r1[22], int'(r2[19:16]), prev_fl);
                if (r3[3:0] == 4'd0) step(md, 0, 0, 0, 0, 0, 0, 0, 0, r3[31:16], 0, 0, 0);
            end
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule